// File: doc/BRIEF.md
# Load Ordering Speculation Predictor

This block decides, for each load leaving the scheduler, whether the load may run ahead of older stores whose addresses are still unknown, and it learns from how that choice turned out. The decision comes from a table of small saturating confidence counters. A hash of the load's instruction pointer picks the counter. Only a load whose counter has reached its ceiling is allowed to pass unresolved stores. Every other load facing an unresolved older store waits until the core reports that those stores have resolved.

The block also keeps a status record for each in-flight load slot. The record holds a tracked flag, a flag saying the load passed at least one unresolved store, a flag saying it was released to execute, an executed flag with the 8-byte block it touched, and a violation flag. When a store address resolves, the store is compared in parallel against all younger loads that have already executed. A match marks those loads as violators. When a load commits, the table is trained:
- a violator clears its counter and raises a one-cycle replay request carrying its slot tag;
- a clean load that passed unresolved stores increments its counter;
- any other load leaves the table untouched.

Top module: `ldp_predictor`

## Requirements
- R1: The counter used for an instruction pointer `ip` is the one at index `ip[7:2] ^ ip[13:8]` in a 64-entry table. Two pointers that give the same index share one counter.
- R2: `lk_go` is 1 whenever `lk_older_unk` is 0. When `lk_older_unk` is 1, `lk_go` is 1 only if the selected 4-bit counter equals 15. The output is combinational from `lk_ip` in the same cycle.
- R3: A load allocated with `lk_go`=0 shows `ld_blocked[tag]`=1 from the next cycle until `unblk_vld` names its tag. A load allocated with `lk_go`=1 never shows as blocked.
- R4: A store whose address resolves sets the violation flag of every slot that meets all of these conditions:
  - its bit is set in `st_younger`;
  - it is tracked and has already executed;
  - its executed address has the same bits [31:3] as the store address.
  A store that fails any of these conditions marks nothing.
- R5: A commit of a violating load asserts `flush_vld` for exactly one cycle, in the cycle after the commit, with `flush_tag` equal to the committing tag. The same commit clears that load's counter to 0.
- R6: A commit of a load that passed unresolved stores and has no violation increments its counter. The counter stops at 15 and does not wrap.
- R7: A commit of a load that passed no unresolved store changes no counter and raises no replay.
- R8: A store that resolves in the same cycle as the commit of a matching load marks the load as a violator for that commit. A store that resolves in the same cycle as a matching load's execution also marks that load.
- R9: A lookup made in the same cycle as a training update to the same counter sees the value before the update. Lookups from the next cycle see the new value.
- R10: After reset all counters are 0, no slot is blocked and `flush_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_vld | input | 1 | Load dispatch: allocate a slot |
| lk_tag | input | 3 | Slot tag of the dispatching load |
| lk_ip | input | 32 | Instruction pointer of the dispatching load |
| lk_older_unk | input | 1 | An older store with an unknown address exists |
| lk_go | output | 1 | Prediction: the load may run now |
| unblk_vld | input | 1 | All older stores of a blocked load are resolved |
| unblk_tag | input | 3 | Tag of the released load |
| ex_vld | input | 1 | A load executes |
| ex_tag | input | 3 | Tag of the executing load |
| ex_addr | input | 32 | Address accessed by the executing load |
| st_vld | input | 1 | A store address resolves |
| st_addr | input | 32 | Resolved store address |
| st_younger | input | 8 | Slots holding loads younger than this store |
| cm_vld | input | 1 | A load commits |
| cm_tag | input | 3 | Tag of the committing load |
| flush_vld | output | 1 | Replay request for a mispredicted load |
| flush_tag | output | 3 | Tag of the load to replay |
| ld_blocked | output | 8 | Per-slot: load waits for older store addresses |

## Verification
The bench drives a store address resolution in the same cycle as the commit of a load that executed to the same 8-byte block. The replay request must appear on the next cycle, and afterwards the trained counter must read as cleared rather than incremented. The bench also drives the store in the same cycle as the load's execution and checks that the commit then replays. For the timing of training, a lookup is driven in the commit cycle of the fifteenth clean instance. The prediction must still be "wait" during that cycle and turn to "go" one cycle later.

// File: rtl/ldp_pkg.sv
package ldp_pkg;

  typedef enum logic {
    TR_INC = 1'b0,
    TR_CLR = 1'b1
  } train_op_e;

  typedef struct packed {
    logic tracked;
    logic passed;
    logic released;
    logic executed;
    logic violated;
  } slot_stat_t;

endpackage

// File: rtl/ldp_hist_table.sv
module ldp_hist_table
  import ldp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             tr_vld,
  input  train_op_e        tr_op,
  input  logic [IDX_W-1:0] tr_idx
);

  localparam int NUM_ENT = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [CTR_W-1:0] ctr_q [NUM_ENT];
  logic [CTR_W-1:0] ctr_d [NUM_ENT];

  always_comb begin
    ctr_d = ctr_q;
    if (tr_vld) begin
      case (tr_op)
        TR_CLR:  ctr_d[tr_idx] = '0;
        default: begin
          if (ctr_q[tr_idx] != CTR_MAX) ctr_d[tr_idx] = ctr_q[tr_idx] + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ctr_q[i] <= '0;
    end else if (tr_vld) begin
      ctr_q <= ctr_d;
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

  p_clear_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_vld && tr_op == TR_CLR) |=> (ctr_q[$past(tr_idx)] == '0));

  p_saturate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_vld && tr_op == TR_INC && ctr_q[tr_idx] == CTR_MAX) |=> (ctr_q[$past(tr_idx)] == CTR_MAX));

endmodule

// File: rtl/ldp_load_buffer.sv
module ldp_load_buffer
  import ldp_pkg::*;
#(
  parameter int NUM_LD = 8,
  parameter int ADDR_W = 32,
  parameter int GRAN   = 3,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = $clog2(NUM_LD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              al_vld,
  input  logic [TAG_W-1:0]  al_tag,
  input  logic [IDX_W-1:0]  al_idx,
  input  logic              al_passed,
  input  logic              al_go,
  input  logic              unblk_vld,
  input  logic [TAG_W-1:0]  unblk_tag,
  input  logic              ex_vld,
  input  logic [TAG_W-1:0]  ex_tag,
  input  logic [ADDR_W-1:GRAN] ex_blk,
  input  logic              st_vld,
  input  logic [ADDR_W-1:GRAN] st_blk,
  input  logic [NUM_LD-1:0] st_younger,
  input  logic              cm_vld,
  input  logic [TAG_W-1:0]  cm_tag,
  output logic              cm_violated,
  output logic              cm_passed,
  output logic [IDX_W-1:0]  cm_idx,
  output logic [NUM_LD-1:0] blocked
);

  slot_stat_t          stat_q [NUM_LD];
  slot_stat_t          stat_d [NUM_LD];
  logic [ADDR_W-1:GRAN] blk_q [NUM_LD];
  logic [ADDR_W-1:GRAN] blk_d [NUM_LD];
  logic [IDX_W-1:0]    idx_q [NUM_LD];
  logic [IDX_W-1:0]    idx_d [NUM_LD];
  logic [NUM_LD-1:0]   hit;

  // Parallel compare of a resolving store against every slot; a load
  // executing in this very cycle is compared on its incoming address.
  for (genvar g = 0; g < NUM_LD; g++) begin : g_cmp
    logic                 exec_now;
    logic [ADDR_W-1:GRAN] cmp_blk;
    assign exec_now = ex_vld && (ex_tag == TAG_W'(g));
    assign cmp_blk  = exec_now ? ex_blk : blk_q[g];
    assign hit[g]   = st_vld && st_younger[g] && stat_q[g].tracked &&
                      (stat_q[g].executed || exec_now) && (cmp_blk == st_blk);
    assign blocked[g] = stat_q[g].tracked && !stat_q[g].released;
  end

  always_comb begin
    stat_d = stat_q;
    blk_d  = blk_q;
    idx_d  = idx_q;
    if (unblk_vld) stat_d[unblk_tag].released = 1'b1;
    if (ex_vld) begin
      stat_d[ex_tag].executed = 1'b1;
      blk_d[ex_tag]           = ex_blk;
    end
    for (int i = 0; i < NUM_LD; i++) begin
      if (hit[i]) stat_d[i].violated = 1'b1;
    end
    if (cm_vld) stat_d[cm_tag] = '0;
    if (al_vld) begin
      stat_d[al_tag] = '{tracked: 1'b1, passed: al_passed, released: al_go,
                         executed: 1'b0, violated: 1'b0};
      idx_d[al_tag]  = al_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LD; i++) stat_q[i] <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ex_vld) blk_q <= blk_d;
    if (al_vld) idx_q <= idx_d;
  end

  assign cm_violated = stat_q[cm_tag].violated || hit[cm_tag];
  assign cm_passed   = stat_q[cm_tag].passed;
  assign cm_idx      = idx_q[cm_tag];

  p_exec_only_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_vld |-> (stat_q[ex_tag].tracked && stat_q[ex_tag].released));

  p_unblock_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unblk_vld && !(al_vld && al_tag == unblk_tag)) |=> !blocked[$past(unblk_tag)]);

  p_store_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && !cm_vld && !al_vld && st_younger[0] && stat_q[0].executed &&
     blk_q[0] == st_blk && !(ex_vld && ex_tag == '0)) |=> stat_q[0].violated);

endmodule

// File: rtl/ldp_commit_ctrl.sv
module ldp_commit_ctrl
  import ldp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cm_vld,
  input  logic [TAG_W-1:0] cm_tag,
  input  logic             cm_violated,
  input  logic             cm_passed,
  input  logic [IDX_W-1:0] cm_idx,
  output logic             tr_vld,
  output train_op_e        tr_op,
  output logic [IDX_W-1:0] tr_idx,
  output logic             flush_vld,
  output logic [TAG_W-1:0] flush_tag
);

  logic             flush_d;
  logic [TAG_W-1:0] flush_tag_d;

  always_comb begin
    tr_vld      = cm_vld && (cm_violated || cm_passed);
    tr_op       = cm_violated ? TR_CLR : TR_INC;
    tr_idx      = cm_idx;
    flush_d     = cm_vld && cm_violated;
    flush_tag_d = flush_d ? cm_tag : flush_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_vld <= 1'b0;
      flush_tag <= '0;
    end else begin
      flush_vld <= flush_d;
      if (flush_d) flush_tag <= flush_tag_d;
    end
  end

  p_replay_on_violation_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld && cm_violated) |=> (flush_vld && flush_tag == $past(cm_tag)));

  p_no_replay_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld && !cm_violated && !cm_passed) |-> !tr_vld);

  p_no_spurious_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_vld && cm_violated) |=> !flush_vld);

endmodule

// File: rtl/ldp_predictor.sv
module ldp_predictor
  import ldp_pkg::*;
#(
  parameter int NUM_LD = 8,
  parameter int IP_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 4,
  parameter int GRAN   = 3,
  parameter int TAG_W  = $clog2(NUM_LD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_vld,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [IP_W-1:0]   lk_ip,
  input  logic              lk_older_unk,
  output logic              lk_go,
  input  logic              unblk_vld,
  input  logic [TAG_W-1:0]  unblk_tag,
  input  logic              ex_vld,
  input  logic [TAG_W-1:0]  ex_tag,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [NUM_LD-1:0] st_younger,
  input  logic              cm_vld,
  input  logic [TAG_W-1:0]  cm_tag,
  output logic              flush_vld,
  output logic [TAG_W-1:0]  flush_tag,
  output logic [NUM_LD-1:0] ld_blocked
);

  localparam int LO_LSB = 2;
  localparam int HI_LSB = LO_LSB + IDX_W;
  localparam int HI_MSB = HI_LSB + IDX_W - 1;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [IDX_W-1:0] lk_idx;
  logic [CTR_W-1:0] lk_ctr;
  assign lk_idx = lk_ip[HI_LSB-1:LO_LSB] ^ lk_ip[HI_MSB:HI_LSB];
  assign lk_go  = !lk_older_unk || (lk_ctr == CTR_MAX);

  logic unused_bits;
  assign unused_bits = ^{lk_ip[IP_W-1:HI_MSB+1], lk_ip[LO_LSB-1:0],
                         ex_addr[GRAN-1:0], st_addr[GRAN-1:0]};

  logic             cm_violated, cm_passed, tr_vld;
  logic [IDX_W-1:0] cm_idx, tr_idx;
  train_op_e        tr_op;

  ldp_hist_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_idx (lk_idx),
    .rd_ctr (lk_ctr),
    .tr_vld (tr_vld),
    .tr_op  (tr_op),
    .tr_idx (tr_idx)
  );

  ldp_load_buffer #(.NUM_LD(NUM_LD), .ADDR_W(ADDR_W), .GRAN(GRAN),
                    .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lbuf (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .al_vld      (lk_vld),
    .al_tag      (lk_tag),
    .al_idx      (lk_idx),
    .al_passed   (lk_older_unk),
    .al_go       (lk_go),
    .unblk_vld   (unblk_vld),
    .unblk_tag   (unblk_tag),
    .ex_vld      (ex_vld),
    .ex_tag      (ex_tag),
    .ex_blk      (ex_addr[ADDR_W-1:GRAN]),
    .st_vld      (st_vld),
    .st_blk      (st_addr[ADDR_W-1:GRAN]),
    .st_younger  (st_younger),
    .cm_vld      (cm_vld),
    .cm_tag      (cm_tag),
    .cm_violated (cm_violated),
    .cm_passed   (cm_passed),
    .cm_idx      (cm_idx),
    .blocked     (ld_blocked)
  );

  ldp_commit_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_commit (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cm_vld      (cm_vld),
    .cm_tag      (cm_tag),
    .cm_violated (cm_violated),
    .cm_passed   (cm_passed),
    .cm_idx      (cm_idx),
    .tr_vld      (tr_vld),
    .tr_op       (tr_op),
    .tr_idx      (tr_idx),
    .flush_vld   (flush_vld),
    .flush_tag   (flush_tag)
  );

  p_go_when_free_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_older_unk |-> lk_go);

  p_blocked_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_vld && !lk_go) |=> ld_blocked[$past(lk_tag)]);

  p_released_after_go_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_vld && lk_go) |=> !ld_blocked[$past(lk_tag)]);

  p_flush_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_vld && !$past(flush_vld)) |-> $past(cm_vld));

endmodule

// File: tb/tb_ldp_predictor.sv
module tb_ldp_predictor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_vld, lk_older_unk, unblk_vld, ex_vld, st_vld, cm_vld;
  logic [2:0]  lk_tag, unblk_tag, ex_tag, cm_tag;
  logic [31:0] lk_ip, ex_addr, st_addr;
  logic [7:0]  st_younger;
  logic        lk_go, flush_vld;
  logic [2:0]  flush_tag;
  logic [7:0]  ld_blocked;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldp_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lk_vld(lk_vld), .lk_tag(lk_tag), .lk_ip(lk_ip), .lk_older_unk(lk_older_unk),
    .lk_go(lk_go),
    .unblk_vld(unblk_vld), .unblk_tag(unblk_tag),
    .ex_vld(ex_vld), .ex_tag(ex_tag), .ex_addr(ex_addr),
    .st_vld(st_vld), .st_addr(st_addr), .st_younger(st_younger),
    .cm_vld(cm_vld), .cm_tag(cm_tag),
    .flush_vld(flush_vld), .flush_tag(flush_tag), .ld_blocked(ld_blocked)
  );

  // Saturating at 15 (0xF). Index = ip[7:2]^ip[13:8].
  localparam logic [31:0] IP_S  = 32'h0000_0040; // index 16
  localparam logic [31:0] IP_AL = 32'h0000_1000; // index 16 (alias)
  localparam logic [31:0] IP_X  = 32'h0000_1040; // index 0
  localparam logic [31:0] IP_U  = 32'h0000_0080; // index 32
  localparam logic [31:0] IP_N  = 32'h0000_00C0; // index 48

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    lk_vld = 0; lk_tag = '0; lk_ip = '0; lk_older_unk = 0;
    unblk_vld = 0; unblk_tag = '0; ex_vld = 0; ex_tag = '0; ex_addr = '0;
    st_vld = 0; st_addr = '0; st_younger = '0; cm_vld = 0; cm_tag = '0;
  endtask

  task automatic alloc(input logic [2:0] tag, input logic [31:0] ip, input logic unk);
    lk_vld = 1; lk_tag = tag; lk_ip = ip; lk_older_unk = unk;
    cyc();
    lk_vld = 0; lk_older_unk = 0;
  endtask

  task automatic unblock(input logic [2:0] tag);
    unblk_vld = 1; unblk_tag = tag; cyc(); unblk_vld = 0;
  endtask

  task automatic exec(input logic [2:0] tag, input logic [31:0] a);
    ex_vld = 1; ex_tag = tag; ex_addr = a; cyc(); ex_vld = 0;
  endtask

  task automatic store(input logic [31:0] a, input logic [7:0] m);
    st_vld = 1; st_addr = a; st_younger = m; cyc(); st_vld = 0; st_younger = '0;
  endtask

  task automatic commit(input logic [2:0] tag);
    cm_vld = 1; cm_tag = tag; cyc(); cm_vld = 0;
  endtask

  task automatic probe(input logic [31:0] ip, input logic unk, output logic go);
    lk_ip = ip; lk_older_unk = unk; #1; go = lk_go; lk_older_unk = 0;
  endtask

  // One clean dynamic instance that passed an unresolved store.
  task automatic train(input logic [31:0] ip, input int n);
    for (int k = 0; k < n; k++) begin
      alloc(3'd0, ip, 1'b1);
      if (ld_blocked[0]) unblock(3'd0);
      exec(3'd0, 32'h0000_0F00);
      commit(3'd0);
    end
  endtask

  task automatic t_reset();
    logic go;
    check(32'(ld_blocked), 32'h0, "R10", "blocked after reset");
    check(32'(flush_vld), 32'h0, "R10", "flush after reset");
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h0, "R10", "counter zero gives wait");
    probe(IP_S, 1'b0, go);
    check(32'(go), 32'h1, "R2", "go with no unknown store");
  endtask

  task automatic t_saturate();
    logic go;
    train(IP_S, 14);
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h0, "R6", "wait at count 14");
    alloc(3'd1, IP_S, 1'b1);
    unblock(3'd1);
    exec(3'd1, 32'h0000_0F00);
    cm_vld = 1; cm_tag = 3'd1; lk_ip = IP_S; lk_older_unk = 1; #1;
    check(32'(lk_go), 32'h0, "R9", "same-cycle lookup sees old count");
    cyc(); cm_vld = 0; #1;
    check(32'(lk_go), 32'h1, "R9", "next-cycle lookup sees 15");
    lk_older_unk = 0;
    check(32'(flush_vld), 32'h0, "R6", "clean commit no replay");
    train(IP_S, 3);
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h1, "R6", "counter holds at 15");
  endtask

  task automatic t_alias();
    logic go;
    probe(IP_AL, 1'b1, go);
    check(32'(go), 32'h1, "R1", "aliasing ip shares counter");
    probe(IP_X, 1'b1, go);
    check(32'(go), 32'h0, "R1", "other index untouched");
  endtask

  task automatic t_block();
    alloc(3'd3, IP_U, 1'b1);
    check(32'(ld_blocked[3]), 32'h1, "R3", "unsaturated load blocked");
    cyc();
    check(32'(ld_blocked[3]), 32'h1, "R3", "still blocked while waiting");
    unblock(3'd3);
    check(32'(ld_blocked[3]), 32'h0, "R3", "released after unblock");
    commit(3'd3);
    alloc(3'd4, IP_S, 1'b1);
    check(32'(ld_blocked[4]), 32'h0, "R3", "saturated load not blocked");
    commit(3'd4);
    alloc(3'd5, IP_U, 1'b0);
    check(32'(ld_blocked[5]), 32'h0, "R3", "no unknown store not blocked");
    commit(3'd5);
  endtask

  task automatic t_conflict();
    logic go;
    alloc(3'd2, IP_S, 1'b1);
    exec(3'd2, 32'h0000_1000);
    store(32'h0000_1004, 8'h04);
    commit(3'd2);
    check(32'(flush_vld), 32'h1, "R5", "replay on violation");
    check(32'(flush_tag), 32'h2, "R5", "replay tag");
    cyc();
    check(32'(flush_vld), 32'h0, "R5", "replay lasts one cycle");
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h0, "R5", "counter cleared after violation");
    train(IP_S, 14);
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h0, "R5", "counter restarted from zero");
    train(IP_S, 1);
  endtask

  task automatic t_no_conflict();
    logic go;
    alloc(3'd2, IP_S, 1'b1);
    exec(3'd2, 32'h0000_1000);
    store(32'h0000_1008, 8'h04);
    commit(3'd2);
    check(32'(flush_vld), 32'h0, "R4", "next 8-byte block no mark");
    alloc(3'd2, IP_S, 1'b1);
    exec(3'd2, 32'h0000_1000);
    store(32'h0000_1000, 8'hFB);
    commit(3'd2);
    check(32'(flush_vld), 32'h0, "R4", "older load not marked");
    alloc(3'd2, IP_S, 1'b1);
    store(32'h0000_1000, 8'h04);
    exec(3'd2, 32'h0000_1000);
    commit(3'd2);
    check(32'(flush_vld), 32'h0, "R4", "unexecuted load not marked");
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h1, "R4", "counter kept after clean loads");
  endtask

  task automatic t_no_update();
    logic go;
    train(IP_N, 14);
    alloc(3'd6, IP_N, 1'b0);
    exec(3'd6, 32'h0000_2000);
    commit(3'd6);
    check(32'(flush_vld), 32'h0, "R7", "no replay without passing");
    probe(IP_N, 1'b1, go);
    check(32'(go), 32'h0, "R7", "count unchanged at 14");
    train(IP_N, 1);
    probe(IP_N, 1'b1, go);
    check(32'(go), 32'h1, "R7", "one more reaches 15");
  endtask

  task automatic t_same_cycle();
    logic go;
    alloc(3'd1, IP_S, 1'b1);
    exec(3'd1, 32'h0000_3000);
    st_vld = 1; st_addr = 32'h0000_3007; st_younger = 8'h02;
    cm_vld = 1; cm_tag = 3'd1;
    cyc();
    st_vld = 0; st_younger = '0; cm_vld = 0;
    check(32'(flush_vld), 32'h1, "R8", "store with commit replays");
    check(32'(flush_tag), 32'h1, "R8", "store with commit tag");
    probe(IP_S, 1'b1, go);
    check(32'(go), 32'h0, "R8", "counter cleared not incremented");
    train(IP_S, 15);
    alloc(3'd1, IP_S, 1'b1);
    ex_vld = 1; ex_tag = 3'd1; ex_addr = 32'h0000_3000;
    st_vld = 1; st_addr = 32'h0000_3000; st_younger = 8'h02;
    cyc();
    ex_vld = 0; st_vld = 0; st_younger = '0;
    commit(3'd1);
    check(32'(flush_vld), 32'h1, "R8", "store with execute replays");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_saturate();
    t_alias();
    t_block();
    t_conflict();
    t_no_conflict();
    t_no_update();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule